// File: doc/BRIEF.md
# Measurement Cycle Sequencer

This block decides which input the converter of a bridge-sensor conditioner looks at next. After reset it runs a short start routine once. It then loops through a main cycle without end. In that cycle, groups of pressure conversions are interleaved with single offset (auto-zero) slots and temperature slots. For each step the block presents a channel code to the analog multiplexer and raises a one-cycle conversion request. It then waits for the converter's done pulse before it moves on.

Two inputs configure the block. A 3-bit repeat code selects how many pressure conversions precede each non-pressure slot. A single enable adds or removes the whole second-temperature branch. Both are captured only at the first step of a pass, so a group is never cut short. A step tag goes with every step. It gives the group index and marks the final step of a pass, so the correction logic downstream knows which result register to update.

Top module: `meas_seq`

## Requirements
- R1: While reset is low, `conv_req` is 0, `chan` is 0, `boot_active` is 1 and `step_tag` is 0. The first request is high in the first cycle after reset is released.
- R2: `conv_req` is high for exactly one cycle per step. After a request, the block raises no new request until it has received a done pulse. The next request follows in the cycle after the done pulse that is accepted.
- R3: `chan` does not change between a request and the done pulse that is accepted for it.
- R4: The start routine runs the steps pressure, pressure auto-zero, temperature-1 auto-zero and temperature-1. When the second temperature is enabled, it then adds temperature-2 auto-zero and temperature-2. `boot_active` is 1 during exactly these steps and never returns to 1 until the next reset.
- R5: One main pass consists of groups. Each group holds n pressure steps followed by one tail slot. The tail slots, in order, are temperature-1 auto-zero, temperature-1, pressure auto-zero, temperature-2 auto-zero and temperature-2. After the last group, the pass starts again.
- R6: The repeat code `cfg_rep` = r selects n = 2^r, for r from 0 to 7 (n from 1 to 128).
- R7: With `cfg_t2_en` = 0, a pass has only the first three groups. Their pressure steps and both temperature-2 slots are dropped.
- R8: Channel codes: 0 pressure, 1 pressure auto-zero, 2 temperature-1, 3 temperature-1 auto-zero, 4 temperature-2, 5 temperature-2 auto-zero.
- R9: The configuration is captured during the request of the first step of each pass, including the start routine. A change made at any other time takes effect only from the next pass.
- R10: `step_tag[2:0]` holds the step index within the start routine, or the group index within a main pass. `step_tag[3]` is 1 only on the final step of a pass.
- R11: A done pulse that arrives in the same cycle as the request is ignored. The step does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rep | input | 3 | Pressure repeat code, n = 2^code |
| cfg_t2_en | input | 1 | Enables the second-temperature branch |
| conv_done | input | 1 | Conversion-complete pulse from the converter |
| conv_req | output | 1 | One-cycle conversion request |
| chan | output | 3 | Channel code for the multiplexer |
| boot_active | output | 1 | High during the start routine |
| step_tag | output | 4 | {pass-end flag, group or start-step index} |

## Verification
The bench sweeps every repeat code with the second temperature both on and off. It follows each configuration through the start routine and two full passes, and it predicts every channel and tag from the position of the step within the pass. These runs hit the edges where an off-by-one counter would add or lose one pressure step before a tail slot, and where a bad wrap would skip the pressure auto-zero group or keep the temperature-2 groups when they are disabled. The bench also changes the configuration in the middle of a pass. A design that captures it at the wrong moment would shorten the current group or pass. Early done pulses, which arrive together with the request, catch a handshake that advances too soon. Varied response delays catch a channel that drifts while a conversion is running.

// File: rtl/meas_seq_pkg.sv
package meas_seq_pkg;

  localparam int CHAN_W = 3;
  localparam int GRP_W  = 3;
  localparam int TAG_W  = GRP_W + 1;

  typedef enum logic [CHAN_W-1:0] {
    CH_PRS    = 3'd0,
    CH_PRS_AZ = 3'd1,
    CH_T1     = 3'd2,
    CH_T1_AZ  = 3'd3,
    CH_T2     = 3'd4,
    CH_T2_AZ  = 3'd5
  } chan_e;

  // Slot that closes main-loop group g
  function automatic chan_e tail_chan(input logic [GRP_W-1:0] g);
    case (g)
      3'd0:    return CH_T1_AZ;
      3'd1:    return CH_T1;
      3'd2:    return CH_PRS_AZ;
      3'd3:    return CH_T2_AZ;
      default: return CH_T2;
    endcase
  endfunction

  // Channel of start-routine step s
  function automatic chan_e boot_chan(input logic [GRP_W-1:0] s);
    case (s)
      3'd0:    return CH_PRS;
      3'd1:    return CH_PRS_AZ;
      3'd2:    return CH_T1_AZ;
      3'd3:    return CH_T1;
      3'd4:    return CH_T2_AZ;
      default: return CH_T2;
    endcase
  endfunction

  function automatic logic [GRP_W-1:0] last_group(input logic t2);
    return t2 ? GRP_W'(4) : GRP_W'(2);
  endfunction

  function automatic logic [GRP_W-1:0] last_boot_step(input logic t2);
    return t2 ? GRP_W'(5) : GRP_W'(3);
  endfunction

endpackage

// File: rtl/meas_seq_hs.sv
module meas_seq_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic done_i,
  output logic req_o,
  output logic adv_o
);

  typedef enum logic [1:0] {HS_BOOT, HS_ISSUE, HS_WAIT} hs_e;
  hs_e  state_q;
  logic issued_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= HS_BOOT;
      issued_q <= 1'b0;
    end else begin
      case (state_q)
        HS_BOOT:  state_q <= HS_ISSUE;
        HS_ISSUE: state_q <= HS_WAIT;
        default:  if (done_i) state_q <= HS_ISSUE;
      endcase
      if (req_o) issued_q <= 1'b1;
    end
  end

  assign req_o = (state_q == HS_ISSUE);
  assign adv_o = (state_q == HS_WAIT) && done_i;

  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o);
  assert_req_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && issued_q) |-> $past(done_i));

endmodule

// File: rtl/meas_seq_cfg.sv
module meas_seq_cfg #(
  parameter int REP_W = 3,
  localparam int CNT_W = 1 << REP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [REP_W-1:0] rep_i,
  input  logic             t2_i,
  output logic [CNT_W-1:0] n_o,
  output logic             t2_o
);

  logic [REP_W-1:0] rep_q;
  logic             t2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rep_q <= '0;
      t2_q  <= 1'b0;
    end else if (load_i) begin
      rep_q <= rep_i;
      t2_q  <= t2_i;
    end
  end

  assign n_o  = CNT_W'(1) << rep_q;
  assign t2_o = t2_q;

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable({rep_q, t2_q}));

endmodule

// File: rtl/meas_seq_pos.sv
module meas_seq_pos
  import meas_seq_pkg::*;
#(
  parameter int REP_W = 3,
  localparam int CNT_W = 1 << REP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] n_i,
  input  logic             t2_i,
  output logic             boot_o,
  output logic [GRP_W-1:0] grp_o,
  output logic             tail_o,
  output logic             last_o,
  output logic             head_o
);

  logic             boot_q, head_q;
  logic [GRP_W-1:0] grp_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_q <= 1'b1;
      head_q <= 1'b1;
      grp_q  <= '0;
      cnt_q  <= '0;
    end else if (adv_i) begin
      if (boot_q) begin
        if (grp_q == last_boot_step(t2_i)) begin
          boot_q <= 1'b0;
          grp_q  <= '0;
          cnt_q  <= '0;
          head_q <= 1'b1;
        end else begin
          grp_q  <= grp_q + 1'b1;
          head_q <= 1'b0;
        end
      end else if (cnt_q != n_i) begin
        cnt_q  <= cnt_q + 1'b1;
        head_q <= 1'b0;
      end else if (grp_q == last_group(t2_i)) begin
        grp_q  <= '0;
        cnt_q  <= '0;
        head_q <= 1'b1;
      end else begin
        grp_q  <= grp_q + 1'b1;
        cnt_q  <= '0;
        head_q <= 1'b0;
      end
    end
  end

  assign boot_o = boot_q;
  assign grp_o  = grp_q;
  assign head_o = head_q;
  assign tail_o = !boot_q && (cnt_q == n_i);
  assign last_o = boot_q ? (grp_q == last_boot_step(t2_i))
                         : (tail_o && grp_q == last_group(t2_i));

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= n_i);
  assert_grp_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_q |-> grp_q <= last_group(t2_i));
  assert_boot_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_q |=> !boot_q);
  assert_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && last_o) |=> (head_q && grp_q == '0 && cnt_q == '0));

endmodule

// File: rtl/meas_seq.sv
module meas_seq
  import meas_seq_pkg::*;
#(
  parameter int REP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REP_W-1:0]  cfg_rep,
  input  logic              cfg_t2_en,
  input  logic              conv_done,
  output logic              conv_req,
  output logic [CHAN_W-1:0] chan,
  output logic              boot_active,
  output logic [TAG_W-1:0]  step_tag
);

  localparam int CNT_W = 1 << REP_W;

  logic             adv, load, head, boot, tail, last, t2_q;
  logic [CNT_W-1:0] n_q;
  logic [GRP_W-1:0] grp;
  chan_e            chan_sel;

  meas_seq_hs u_hs (
    .clk(clk), .rst_n(rst_n), .done_i(conv_done),
    .req_o(conv_req), .adv_o(adv)
  );

  assign load = conv_req && head;

  meas_seq_cfg #(.REP_W(REP_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load_i(load),
    .rep_i(cfg_rep), .t2_i(cfg_t2_en), .n_o(n_q), .t2_o(t2_q)
  );

  meas_seq_pos #(.REP_W(REP_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .adv_i(adv), .n_i(n_q), .t2_i(t2_q),
    .boot_o(boot), .grp_o(grp), .tail_o(tail), .last_o(last), .head_o(head)
  );

  always_comb begin
    if (boot)      chan_sel = boot_chan(grp);
    else if (tail) chan_sel = tail_chan(grp);
    else           chan_sel = CH_PRS;
  end

  assign chan        = chan_sel;
  assign boot_active = boot;
  assign step_tag    = {last, grp};

  assert_chan_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(conv_done) |-> $stable(chan));
  assert_early_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && conv_done) |=> $stable(chan) && !conv_req);
  assert_head_pressure_R5: assert property (@(posedge clk) disable iff (!rst_n)
    head |-> chan == CH_PRS);

endmodule

// File: tb/meas_seq_bench.sv
module meas_seq_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_rep = '0;
  logic       cfg_t2_en = 1'b0;
  logic       conv_done = 1'b0;
  logic       conv_req;
  logic [2:0] chan;
  logic       boot_active;
  logic [3:0] step_tag;

  int checks = 0;
  int errors = 0;
  bit dead = 0;

  // model state
  bit m_boot;
  int m_k, m_n, m_t2, m_passes;

  always #4 clk = ~clk;

  meas_seq u_meas_seq (
    .clk(clk), .rst_n(rst_n), .cfg_rep(cfg_rep), .cfg_t2_en(cfg_t2_en),
    .conv_done(conv_done), .conv_req(conv_req), .chan(chan),
    .boot_active(boot_active), .step_tag(step_tag)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int pass_len();
    return (m_t2 != 0 ? 5 : 3) * (m_n + 1);
  endfunction

  function automatic int boot_len();
    return m_t2 != 0 ? 6 : 4;
  endfunction

  // Expected channel from the position of the step in its pass
  function automatic int exp_chan();
    int g, w;
    if (m_boot) begin
      case (m_k)
        0: return 0; 1: return 1; 2: return 3; 3: return 2; 4: return 5;
        default: return 4;
      endcase
    end
    g = m_k / (m_n + 1);
    w = m_k % (m_n + 1);
    if (w < m_n) return 0;
    case (g)
      0: return 3; 1: return 2; 2: return 1; 3: return 5;
      default: return 4;
    endcase
  endfunction

  function automatic int exp_tag();
    int idx, fin;
    if (m_boot) begin
      idx = m_k;
      fin = (m_k == boot_len() - 1) ? 1 : 0;
    end else begin
      idx = m_k / (m_n + 1);
      fin = (m_k == pass_len() - 1) ? 1 : 0;
    end
    return fin * 8 + idx;
  endfunction

  task automatic wait_req(output bit ok);
    ok = 0;
    for (int i = 0; i < 64; i++) begin
      if (conv_req === 1'b1) begin
        ok = 1;
        return;
      end
      @(negedge clk);
    end
  endtask

  task automatic do_step(input int delay, input bit early);
    bit ok;
    string rq;
    int ec;
    wait_req(ok);
    if (!ok) begin
      chk(0, "R2 request missing", 0, 1);
      dead = 1;
      return;
    end
    if (m_k == 0) begin
      m_n  = 1 << cfg_rep;
      m_t2 = cfg_t2_en;
    end
    ec = exp_chan();
    rq = m_boot ? "R4 start channel" : "R5/R6/R7/R8 loop channel";
    chk(chan == ec, rq, chan, ec);
    chk(step_tag == exp_tag(), "R10 tag", step_tag, exp_tag());
    chk(boot_active == m_boot, "R4 start flag", boot_active, m_boot);
    if (early) begin
      conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
      chk(conv_req == 1'b0, "R11 req after early done", conv_req, 0);
      chk(chan == ec, "R11 chan after early done", chan, ec);
    end else begin
      @(negedge clk);
      chk(conv_req == 1'b0, "R2 req one cycle", conv_req, 0);
    end
    for (int d = 0; d < delay; d++) begin
      @(negedge clk);
      chk(conv_req == 1'b0 && chan == ec, "R3 hold while waiting", chan, ec);
    end
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    chk(conv_req == 1'b1, "R2 req after done", conv_req, 1);
    m_k++;
    if (m_boot && m_k == boot_len()) begin
      m_boot = 0;
      m_k = 0;
    end else if (!m_boot && m_k == pass_len()) begin
      m_k = 0;
      m_passes++;
    end
  endtask

  task automatic run(input int rep, input int t2, input int passes,
                     input int chg_at, input int nrep, input int nt2);
    int i;
    rst_n = 1'b0;
    conv_done = 1'b0;
    cfg_rep = 3'(rep);
    cfg_t2_en = t2[0];
    repeat (3) @(negedge clk);
    chk(conv_req == 0 && chan == 0, "R1 reset outputs", {conv_req, chan}, 0);
    chk(boot_active == 1 && step_tag == 0, "R1 reset flag/tag", {boot_active, step_tag}, 16);
    rst_n = 1'b1;
    @(negedge clk);
    chk(conv_req == 1'b1, "R1 first request", conv_req, 1);
    m_boot = 1;
    m_k = 0;
    m_passes = 0;
    i = 0;
    while (m_passes < passes && !dead) begin
      if (i == chg_at) begin
        cfg_rep = 3'(nrep);
        cfg_t2_en = nt2[0];
      end
      do_step(i % 4, (i % 7) == 3);
      i++;
    end
  endtask

  initial begin
    for (int r = 0; r < 8; r++)
      for (int t = 0; t < 2; t++)
        if (!dead) run(r, t, 2, -1, 0, 0);
    // R9: change mid pass, old config must finish its pass
    if (!dead) run(1, 1, 3, 9, 0, 0);
    if (!dead) run(0, 0, 3, 7, 2, 1);
    if (!dead) run(2, 1, 2, 2, 3, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule